// File: doc/BRIEF.md
# Six-Channel Packed TDM Audio Receiver

This block takes six audio channels that share one serial data line in a packed time-division frame and turns them into six parallel sample words. It runs on the serial bit clock and samples data and the frame clock on its rising edge. A mode input picks one of two frame layouts: 128 or 256 bit clocks per frame. A word-length input picks 16, 20 or 24 bits per sample.

The receiver finds the start of each frame from the frame-clock edge that enters the left-group level. On that edge it aligns its bit counter. It then walks the slots and shifts each channel in MSB first. When the last right channel is complete, all six words are loaded into the outputs together, and a single-cycle valid strobe marks the load. A frame-clock edge at a bit position where none belongs raises an error flag. The outputs then keep their old values until a clean frame completes.

Top module: `packed_tdm_rx`

## Requirements
- R1: While reset is held, and after its release until the first update, `validOut` and `errFlag` are 0 and every sample word is 0.
- R2: With `mode256`=0 the frame has 128 positions (0 = first bit after the start edge). Left channels 0, 1 and 2 start at positions 0, 20 and 40. Right channels 0, 1 and 2 start at positions 64, 84 and 104. Positions 60-63 and 124-127 are blank. The MSB is taken at the channel's start position.
- R3: With `mode256`=1 the frame has 256 positions in eight 32-bit slots. Slots 0-2 carry left channels 0-2 and slots 4-6 carry right channels 0-2. Slots 3 and 7 are blank. The MSB is taken at offset 1 of the slot.
- R4: `wordSel` 0 selects 16 bits, 1 selects 20 bits, and 2 or 3 select 24 bits. Bits inside a slot after the selected word length, and bits in blank positions, have no effect. Each word is right-justified in its 24-bit field, with the unused upper bits 0.
- R5: With `mode256`=0 the word length never exceeds 20 bits. A `wordSel` of 2 or 3 acts as 20 bits.
- R6: The frame start is a rising `frameClk` edge when `mode256`=0 and a falling edge when `mode256`=1. The edge position becomes position 0.
- R7: All six words are loaded together, with `validOut` high for exactly one bit clock. That cycle follows the rising edge that samples position 124 (128 mode) or position 224 (256 mode).
- R8: A `frameClk` edge at an unexpected position raises `errFlag`. This covers a start edge not directly after the last position of the frame, and an edge into the right level at any position other than 64 (128 mode) or 128 (256 mode). That frame then gives no valid strobe and the sample words hold.
- R9: A frame that starts with a misplaced start edge is also rejected. The next frame that starts with a correctly placed edge and has no error loads the outputs, and its valid strobe clears `errFlag`.
- R10: Before the first start edge after reset, no `frameClk` level or data gives a valid strobe or an error.
- R11: Sample word k occupies bits [24k+23:24k] of `samples`, with k = 0, 1, 2 for left channels 0-2 and k = 3, 4, 5 for right channels 0-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameClk | input | 1 | Left/right frame clock |
| serData | input | 1 | Serial audio data, MSB first |
| mode256 | input | 1 | 0: 128 bit clocks per frame, 1: 256 |
| wordSel | input | 2 | Word length: 0=16, 1=20, 2/3=24 bits |
| samples | output | 144 | Six right-justified 24-bit sample words |
| validOut | output | 1 | One-cycle strobe when all six words load |
| errFlag | output | 1 | Framing error, held until the next clean frame |

## Verification
The bench fills the bit positions past each word's length and the blank positions with random bits. A receiver that took a bit too many, dropped the one-bit MSB offset in 256 mode, or kept more than 20 bits in 128 mode would then corrupt the words. It moves the left/right edge early and cuts a frame short so that the next start edge is misplaced. A receiver that ignored misplaced edges, loaded a damaged frame, or failed to resynchronise would show a wrong valid count, a stale error flag or changed words. Every layout and word-length pairing is covered, including both start-edge polarities.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int WORD_MAX = 24;
  localparam int NUM_CH   = 6;
  localparam int CH_W     = 3;

  // strobes from control to datapath for one bit position
  typedef struct packed {
    logic            capture;  // shift serData into channel chan
    logic            first;    // this bit is the MSB: restart the word
    logic [CH_W-1:0] chan;
    logic            update;   // load all outputs
  } dpCtl_t;
endpackage

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
  import tdm_rx_pkg::*;
#(
  parameter int WORD_MAX = tdm_rx_pkg::WORD_MAX
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic       mode256,
  input  logic [1:0] wordSel,
  output dpCtl_t     ctl,
  output logic       errFlag
);
  localparam int CNT_W = 8;

  logic             fcPrev, locked, frameBad;
  logic [CNT_W-1:0] bitCnt, nextCnt, pos, lastPos, halfPos, updPos;
  logic             startEdge, midEdge, errNow;
  logic [4:0]       effLen, off;
  logic [5:0]       halfOff;
  logic [2:0]       slotNum, idx;
  logic             inSlot;

  always_comb begin
    lastPos   = mode256 ? 8'd255 : 8'd127;
    halfPos   = mode256 ? 8'd128 : 8'd64;
    updPos    = mode256 ? 8'd224 : 8'd124;
    // left level is high in 128 mode, low in 256 mode
    startEdge = (fcPrev != frameClk) && (frameClk == !mode256);
    midEdge   = (fcPrev != frameClk) && !startEdge;
    nextCnt   = (bitCnt == lastPos) ? '0 : bitCnt + 8'd1;
    pos       = startEdge ? '0 : nextCnt;
    errNow    = locked && ((startEdge && bitCnt != lastPos) ||
                           (midEdge && nextCnt != halfPos));
    case (wordSel)
      2'd0:    effLen = 5'd16;
      2'd1:    effLen = 5'd20;
      default: effLen = mode256 ? 5'(WORD_MAX) : 5'd20;
    endcase
  end

  // slot decode
  always_comb begin
    slotNum = pos[7:5];
    halfOff = pos[5:0];
    idx     = '0;
    off     = '0;
    inSlot  = 1'b0;
    ctl     = '0;
    if (mode256) begin
      off        = pos[4:0];
      inSlot     = slotNum[1:0] != 2'b11;
      idx        = slotNum[2] ? slotNum - 3'd1 : slotNum;
      ctl.capture = inSlot && off != 5'd0 && off <= effLen;
      ctl.first   = off == 5'd1;
    end else begin
      inSlot = 1'b1;
      if (halfOff < 6'd20) begin
        idx = 3'd0; off = 5'(halfOff);
      end else if (halfOff < 6'd40) begin
        idx = 3'd1; off = 5'(halfOff - 6'd20);
      end else if (halfOff < 6'd60) begin
        idx = 3'd2; off = 5'(halfOff - 6'd40);
      end else begin
        inSlot = 1'b0;
      end
      if (pos[6]) idx = idx + 3'd3;
      ctl.capture = inSlot && off < effLen;
      ctl.first   = off == 5'd0;
    end
    ctl.chan   = idx;
    ctl.update = locked && !frameBad && !errNow && pos == updPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fcPrev   <= 1'b0;
      bitCnt   <= '0;
      locked   <= 1'b0;
      frameBad <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      fcPrev <= frameClk;
      bitCnt <= pos;
      if (startEdge) locked <= 1'b1;
      if (startEdge)   frameBad <= errNow;
      else if (errNow) frameBad <= 1'b1;
      if (errNow)          errFlag <= 1'b1;
      else if (ctl.update) errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_rx_dp.sv
module tdm_rx_dp
  import tdm_rx_pkg::*;
#(
  parameter int WORD_MAX = tdm_rx_pkg::WORD_MAX,
  parameter int NUM_CH   = tdm_rx_pkg::NUM_CH
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serData,
  input  dpCtl_t                     ctl,
  output logic [NUM_CH*WORD_MAX-1:0] samples,
  output logic                       validOut
);
  for (genvar k = 0; k < NUM_CH; k++) begin : gChan
    logic [WORD_MAX-1:0] work, held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        work <= '0;
        held <= '0;
      end else begin
        if (ctl.capture && ctl.chan == CH_W'(k))
          work <= ctl.first ? {{(WORD_MAX-1){1'b0}}, serData}
                            : {work[WORD_MAX-2:0], serData};
        if (ctl.update) held <= work;
      end
    end
    assign samples[k*WORD_MAX +: WORD_MAX] = held;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= ctl.update;
  end
endmodule

// File: rtl/packed_tdm_rx.sv
module packed_tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int WORD_MAX = tdm_rx_pkg::WORD_MAX,
  parameter int NUM_CH   = tdm_rx_pkg::NUM_CH
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameClk,
  input  logic                       serData,
  input  logic                       mode256,
  input  logic [1:0]                 wordSel,
  output logic [NUM_CH*WORD_MAX-1:0] samples,
  output logic                       validOut,
  output logic                       errFlag
);
  dpCtl_t ctl;

  tdm_rx_ctrl #(.WORD_MAX(WORD_MAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .mode256(mode256),
    .wordSel(wordSel), .ctl(ctl), .errFlag(errFlag)
  );

  tdm_rx_dp #(.WORD_MAX(WORD_MAX), .NUM_CH(NUM_CH)) i_dp (
    .clk(clk), .rstN(rstN), .serData(serData), .ctl(ctl),
    .samples(samples), .validOut(validOut)
  );
endmodule

// File: rtl/packed_tdm_rx_chk.sv
module packed_tdm_rx_chk #(
  parameter int WORD_MAX = 24,
  parameter int NUM_CH   = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       mode256,
  input logic [1:0]                 wordSel,
  input logic [NUM_CH*WORD_MAX-1:0] samples,
  input logic                       validOut,
  input logic                       errFlag
);
  // R7: strobe lasts one cycle
  assert_single_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);

  // R8: words only change together with the strobe
  assert_hold_words_R8: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> $stable(samples));

  // R9: a load always clears the error
  assert_clean_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> !errFlag);

  for (genvar k = 0; k < NUM_CH; k++) begin : gWord
    // R4: 16-bit words have zero upper bits
    assert_word16_R4: assert property (@(posedge clk) disable iff (!rstN)
      (validOut && wordSel == 2'd0) |->
        samples[k*WORD_MAX+16 +: WORD_MAX-16] == '0);
    // R5: 128 mode words never exceed 20 bits
    assert_cap128_R5: assert property (@(posedge clk) disable iff (!rstN)
      (validOut && !mode256) |->
        samples[k*WORD_MAX+20 +: WORD_MAX-20] == '0);
  end
endmodule

bind packed_tdm_rx packed_tdm_rx_chk #(.WORD_MAX(WORD_MAX), .NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rstN(rstN), .mode256(mode256), .wordSel(wordSel),
  .samples(samples), .validOut(validOut), .errFlag(errFlag)
);

// File: tb/test_packed_tdm_rx.sv
module test_packed_tdm_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_MAX   = 24;
  localparam int NUM_CH     = 6;

  logic clk = 1'b0, rstN = 1'b0, frameClk = 1'b0, serData = 1'b0, mode256 = 1'b0;
  logic [1:0] wordSel = 2'd0;
  logic [NUM_CH*WORD_MAX-1:0] samples;
  logic validOut, errFlag;

  int tests = 0, fails = 0, validSeen = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [WORD_MAX-1:0] expWords [NUM_CH];
  logic [WORD_MAX-1:0] sendWords [NUM_CH];

  packed_tdm_rx i_packed_tdm_rx (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .serData(serData),
    .mode256(mode256), .wordSel(wordSel), .samples(samples),
    .validOut(validOut), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int effLen();
    if (wordSel == 2'd0) return 16;
    if (wordSel == 2'd1) return 20;
    return mode256 ? 24 : 20;
  endfunction

  task automatic sendBit(input logic f, input logic d);
    @(negedge clk);
    frameClk = f;
    serData  = d;
    @(posedge clk);
    #1;
    if (validOut) validSeen++;
  endtask

  task automatic checkWords(input string req);
    for (int c = 0; c < NUM_CH; c++)
      check(req, $sformatf("word %0d", c),
            32'(samples[c*WORD_MAX +: WORD_MAX]), 32'(expWords[c]));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    frameClk = mode256;              // right-group level
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid in reset", 32'(validOut), 0);
    check("R1", "err in reset", 32'(errFlag), 0);
    for (int c = 0; c < NUM_CH; c++) expWords[c] = '0;
    checkWords("R1");
    rstN = 1'b1;
    // R10: idle bits before the first start edge
    validSeen = 0;
    for (int i = 0; i < 9; i++) sendBit(mode256, nextRand()[9]);
    check("R10", "valid before lock", 32'(validSeen), 0);
    check("R10", "err before lock", 32'(errFlag), 0);
  endtask

  // one frame; badMid < 0 puts the left/right edge at its proper place
  task automatic runFrame(input int len, input int badMid, input bit expValid,
                          input bit expErr, input string req);
    int  n     = effLen();
    int  half  = mode256 ? 128 : 64;
    int  upd   = mode256 ? 224 : 124;
    int  trans = (badMid >= 0) ? badMid : half;
    logic leftLvl = !mode256;
    logic [31:0] r;
    logic f, d;
    validSeen = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      r = nextRand();
      sendWords[c] = r[WORD_MAX-1:0];
    end
    for (int p = 0; p < len; p++) begin
      r = nextRand();
      f = (p < trans) ? leftLvl : !leftLvl;
      d = r[17];
      for (int c = 0; c < NUM_CH; c++) begin
        int st;
        if (mode256) st = ((c < 3) ? c : c + 1) * 32 + 1;
        else         st = (c < 3) ? c * 20 : 64 + (c - 3) * 20;
        if (p >= st && p < st + n) d = sendWords[c][n - 1 - (p - st)];
      end
      sendBit(f, d);
      if (p == upd) check(req, "valid at load position", 32'(validOut), 32'(expValid));
    end
    if (expValid)
      for (int c = 0; c < NUM_CH; c++)
        expWords[c] = sendWords[c] & WORD_MAX'((32'd1 << n) - 1);
    check(req, "valid count", 32'(validSeen), 32'(expValid));
    check(req, "err flag", 32'(errFlag), 32'(expErr));
    checkWords(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < (m ? 4 : 3); s++) begin
        int flen;
        string lay;
        mode256 = m[0];
        wordSel = 2'(s);
        flen = m ? 256 : 128;
        // R2 for 128 mode, R3 for 256 mode; R4/R5 via wordSel; R6 both polarities; R11 word order
        lay = m ? "R3/R4/R6/R11" : (s == 2 ? "R5/R2" : "R2/R4/R6/R11");
        doReset();
        runFrame(flen, -1, 1, 0, lay);
        runFrame(flen, -1, 1, 0, "R7");
        // R8: early left/right edge
        runFrame(flen, m ? 100 : 50, 0, 1, "R8");
        runFrame(flen, -1, 1, 0, "R9");
        // short frame, no error yet
        runFrame(m ? 200 : 100, -1, 0, 0, "R8");
        // R9: frame started by a misplaced start edge is rejected
        runFrame(flen, -1, 0, 1, "R9");
        runFrame(flen, -1, 1, 0, "R9");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule